// File: doc/BRIEF.md
# Word-Length Programmable SPI Master

This block is a serial peripheral interface master that a processor drives through eight byte-wide registers. Software sets the bit count of a word (1 to 32), the clock polarity and phase, and a power-of-two clock divisor. It then writes the outgoing word into four data bytes. Writing the least significant data byte hands the whole word to the shift engine, so bytes 1 to 3 must be written before byte 0. Reading the same four addresses returns the most recently received word.

Each direction has one word of buffering beyond the shifter. Software can queue the next word while the current one is on the wire, and a finished receive word waits in its own register while the next one arrives. When a word is queued in time, the engine moves straight on to it: the chip select stays asserted and the clock edges stay evenly spaced. Chip select is either driven by the engine around each burst or forced by software. A status register and a maskable interrupt report progress.

Top module: `wordspi_master`

## Requirements
- R1: After reset, cs_n and sck are high and low respectively, irq is low, the status register (address 7) reads 0x02, the length register (address 6) reads 0x07, and the control (address 4) and configuration (address 5) registers read 0x00.
- R2: Writes to addresses 1, 2 and 3 only stage bits 15:8, 23:16 and 31:24 of the outgoing word and start nothing. A write to address 0 supplies bits 7:0 and queues the complete word. Reads of addresses 0 to 3 return the matching byte of the receive register.
- R3: Length register bits 4:0 hold the word length minus one. Only the low n bits of the queued word are sent, bit n-1 first. The n received bits fill receive bits n-1:0 in arrival order, and the bits above them read as zero.
- R4: Control bits 3:0 hold a rate code k. Every SCK half period lasts 2^k system clocks, and codes above 9 behave as 9, which gives divisors from 2 to 1024.
- R5: Control bit 4 sets the idle SCK level, and control bit 5 selects the phase. With phase 0, MOSI is valid before each leading edge and both sides sample on the leading edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge. SCK returns to the idle level after a word.
- R6: In automatic select mode, cs_n falls one SCK half period before the first clock edge and rises one half period after the last clock edge.
- R7: A word queued while another is shifting is sent directly after it. cs_n stays low between the two words, and every clock edge keeps the half-period spacing. Status bit 1 (transmit holding empty) is high once the queued word has moved into the shifter.
- R8: Status bit 0 is busy, bit 1 is transmit holding empty, bit 2 is receive valid and bit 3 is receive overrun. Reading address 0 clears receive valid. Writing address 7 with bit 3 set clears overrun. A word that completes while receive valid is still set raises overrun, and the receive register takes the newer word.
- R9: Configuration bit 0 enables irq, and irq is high exactly when it is enabled and receive valid is set. Bit 1 selects manual chip select, in which case cs_n is the inverse of bit 2 and transfers do not move it.

Note that the R4 range follows from k running 0 to 9: the full SCK period is two half periods, so the divisor is 2^(k+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (used for read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that the control and length registers are not rewritten while a word is shifting. They also assume that MISO settles on the edge opposite to the one that samples it. The bench writes configuration only while status shows the block idle. Its slave model changes MISO on the non-sampling edge and checks the bits it receives against the queued words. Divider and chip-select timing are measured as the spacing between cs_n and SCK transitions. The back-to-back, overrun, interrupt and manual-select cases are driven one at a time, each from an idle state.

// File: rtl/wordspi_master.sv
module wordspi_master #(
  parameter int unsigned MAX_RATE = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic       cs_n
);
  localparam int unsigned CW = MAX_RATE + 1;

  typedef enum logic [1:0] {IDLE, RUN, TAIL} st_t;

  st_t         state;
  logic [3:0]  rate;
  logic        cpol, cpha;
  logic        irq_en, cs_man, cs_lvl;
  logic [4:0]  lenm1;
  logic [23:0] tx_stage;
  logic [31:0] tx_hold, tx_sh, rx_sh, rx_buf;
  logic        tx_full, rx_valid, rx_ovr;
  logic        mosi_q, sck_int, phase;
  logic [5:0]  bits_left;
  logic [CW-1:0] cnt;

  wire [5:0]    len      = {1'b0, lenm1} + 6'd1;
  wire [3:0]    rate_c   = (rate > 4'(MAX_RATE)) ? 4'(MAX_RATE) : rate;
  wire [CW-1:0] half_m1  = (CW'(1) << rate_c) - CW'(1);
  wire          tick     = (cnt == half_m1);
  wire          wr_hit0  = reg_wr && (reg_addr == 3'd0);
  wire          rd_hit0  = reg_rd && (reg_addr == 3'd0);
  wire [31:0]   tx_align = tx_hold << (6'd32 - len);
  wire          trail    = (state == RUN) && tick && phase;
  wire          last_bit = trail && (bits_left == 6'd1);
  wire [31:0]   rx_next  = cpha ? {rx_sh[30:0], miso} : rx_sh;
  wire          reload   = tx_full && ((state == IDLE) || last_bit);
  wire          busy     = (state != IDLE) || tx_full;

  assign sck  = sck_int ^ cpol;
  assign mosi = mosi_q;
  assign cs_n = cs_man ? !cs_lvl : (state == IDLE);
  assign irq  = irq_en && rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate     <= '0;
      cpol     <= 1'b0;
      cpha     <= 1'b0;
      irq_en   <= 1'b0;
      cs_man   <= 1'b0;
      cs_lvl   <= 1'b0;
      lenm1    <= 5'd7;
      tx_stage <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd1: tx_stage[7:0]   <= reg_wdata;
        3'd2: tx_stage[15:8]  <= reg_wdata;
        3'd3: tx_stage[23:16] <= reg_wdata;
        3'd4: {cpha, cpol, rate} <= reg_wdata[5:0];
        3'd5: {cs_lvl, cs_man, irq_en} <= reg_wdata[2:0];
        3'd6: lenm1 <= reg_wdata[4:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold <= '0;
      tx_full <= 1'b0;
    end else begin
      if (reload) tx_full <= 1'b0;
      if (wr_hit0) begin
        tx_hold <= {tx_stage, reg_wdata};
        tx_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      phase     <= 1'b0;
      sck_int   <= 1'b0;
      mosi_q    <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      bits_left <= '0;
    end else begin
      cnt <= ((state == IDLE) || tick) ? '0 : cnt + CW'(1);
      case (state)
        IDLE: ;
        RUN: if (tick) begin
          sck_int <= !phase;
          phase   <= !phase;
          if (!phase) begin
            if (cpha) begin
              mosi_q <= tx_sh[31];
              tx_sh  <= tx_sh << 1;
            end else begin
              rx_sh <= {rx_sh[30:0], miso};
            end
          end else begin
            rx_sh     <= rx_next;
            bits_left <= bits_left - 6'd1;
            if (!cpha) begin
              mosi_q <= tx_sh[31];
              tx_sh  <= tx_sh << 1;
            end
            if (bits_left == 6'd1 && !tx_full) state <= TAIL;
          end
        end
        TAIL: if (tick) state <= IDLE;
        default: state <= IDLE;
      endcase
      if (reload) begin
        state     <= RUN;
        phase     <= 1'b0;
        bits_left <= len;
        rx_sh     <= '0;
        tx_sh     <= cpha ? tx_align : (tx_align << 1);
        if (!cpha) mosi_q <= tx_align[31];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf   <= '0;
      rx_valid <= 1'b0;
      rx_ovr   <= 1'b0;
    end else begin
      if (rd_hit0) rx_valid <= 1'b0;
      if (reg_wr && (reg_addr == 3'd7) && reg_wdata[3]) rx_ovr <= 1'b0;
      if (last_bit) begin
        rx_buf   <= rx_next;
        rx_valid <= 1'b1;
        if (rx_valid && !rd_hit0) rx_ovr <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = rx_buf[7:0];
      3'd1:    reg_rdata = rx_buf[15:8];
      3'd2:    reg_rdata = rx_buf[23:16];
      3'd3:    reg_rdata = rx_buf[31:24];
      3'd4:    reg_rdata = {2'b00, cpha, cpol, rate};
      3'd5:    reg_rdata = {5'b0, cs_lvl, cs_man, irq_en};
      3'd6:    reg_rdata = {3'b0, lenm1};
      default: reg_rdata = {4'b0, rx_ovr, rx_valid, !tx_full, busy};
    endcase
  end

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != RUN) |-> (sck == cpol));

  // R4
  sck_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_int) |-> ($past(tick) && $past(state) == RUN));

  // R6
  cs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sck_int) && !cs_man && !$past(cs_man)) |-> (!cs_n && !$past(cs_n)));

  // R3
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN) |-> (bits_left != 6'd0 && bits_left <= len));

  // R7
  hold_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_full) |-> (state == RUN));

  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_valid));

endmodule

// File: tb/wordspi_master_test.sv
module wordspi_master_test;
  logic       clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       miso = 1'b0;
  wire  [7:0] reg_rdata;
  wire        irq, sck, mosi, cs_n;

  wordspi_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // mode[1] = clock polarity, mode[0] = clock phase
  localparam int NV = 7;
  localparam logic [74:0] VEC [NV] = '{
    {2'd0, 4'd0,  5'd7,  32'h000000A5, 32'h0000003C},
    {2'd1, 4'd1,  5'd15, 32'h1234BEEF, 32'hFFFF5AC3},
    {2'd2, 4'd2,  5'd31, 32'hDEADBEEF, 32'h0F1E2D3C},
    {2'd3, 4'd0,  5'd4,  32'h00000013, 32'h0000000A},
    {2'd0, 4'd3,  5'd0,  32'h00000001, 32'h00000001},
    {2'd3, 4'd9,  5'd11, 32'h00000ABC, 32'h00000123},
    {2'd1, 4'd15, 5'd2,  32'h00000005, 32'h00000006}
  };

  logic        cpol_b = 1'b0, cpha_b = 1'b0;
  int          len_b = 8;
  logic [31:0] s_tx = '0, s_tx2 = '0, s_rx = '0;
  logic [31:0] s_got [4];
  int          s_pos = 0, s_cnt = 0, s_ngot = 0;

  always @(negedge cs_n) begin
    s_pos = len_b - 1;
    s_cnt = 0;
    s_rx  = '0;
    miso  = s_tx[s_pos];
  end

  always @(sck) begin
    if (!cs_n) begin
      if ((sck != cpol_b) != cpha_b) begin
        s_rx = {s_rx[30:0], mosi};
        s_cnt++;
        if (s_cnt == len_b) begin
          if (s_ngot < 4) s_got[s_ngot] = s_rx;
          s_ngot++;
          s_cnt = 0;
          s_rx  = '0;
        end
      end else if (cpha_b) begin
        miso = s_tx[s_pos];
        if (s_pos == 0) begin s_tx = s_tx2; s_pos = len_b - 1; end
        else s_pos--;
      end else begin
        if (s_pos == 0) begin s_tx = s_tx2; s_pos = len_b - 1; end
        else s_pos--;
        miso = s_tx[s_pos];
      end
    end
  end

  int   last_evt = 0, gmin = 1000000, gmax = 0, cs_rise = 0;
  logic prev_cs = 1'b1, prev_sck = 1'b0;
  always @(negedge clk) begin
    if (prev_cs && !cs_n) last_evt = cyc;
    else if (!cs_n && sck !== prev_sck) begin
      if (cyc - last_evt < gmin) gmin = cyc - last_evt;
      if (cyc - last_evt > gmax) gmax = cyc - last_evt;
      last_evt = cyc;
    end else if (!prev_cs && cs_n) begin
      if (cyc - last_evt < gmin) gmin = cyc - last_evt;
      if (cyc - last_evt > gmax) gmax = cyc - last_evt;
      cs_rise++;
    end
    prev_cs  = cs_n;
    prev_sck = sck;
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      reg_addr = 3'd7;
      #1;
      if (reg_rdata[0] == 1'b0) break;
    end
  endtask

  task automatic clear_gaps();
    gmin = 1000000; gmax = 0; cs_rise = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] w, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 cs_n", cs_n, 1);
    check("R1 sck", sck, 0);
    check("R1 irq", irq, 0);
    rd(3'd7, b); check("R1 status", b, 8'h02);
    rd(3'd6, b); check("R1 length", b, 8'h07);
    rd(3'd4, b); check("R1 control", b, 8'h00);
    rd(3'd5, b); check("R1 config", b, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  mode;
      logic [3:0]  rt;
      logic [4:0]  lm1;
      logic [31:0] tx, sl;
      int          half;
      {mode, rt, lm1, tx, sl} = VEC[i];
      half = 1 << ((rt > 4'd9) ? 9 : int'(rt));
      m = (lm1 == 5'd31) ? 32'hFFFFFFFF : ((32'd1 << (lm1 + 1)) - 32'd1);
      wr(3'd4, {2'b00, mode[0], mode[1], rt});
      cpol_b = mode[1]; cpha_b = mode[0]; len_b = int'(lm1) + 1;
      wr(3'd6, {3'b000, lm1});
      s_tx = sl; s_tx2 = sl; s_ngot = 0;
      wr(3'd3, tx[31:24]); wr(3'd2, tx[23:16]); wr(3'd1, tx[15:8]);
      rd(3'd7, b); check("R2 staging starts nothing", b, 8'h02);
      clear_gaps();
      wr(3'd0, tx[7:0]);
      wait_idle();
      check("R2 one word sent", s_ngot, 1);
      check("R3 slave word", s_got[0], tx & m);
      check("R4 R6 min spacing", gmin, half);
      check("R4 R6 max spacing", gmax, half);
      check("R5 idle level", sck, mode[1]);
      rd(3'd7, b); check("R8 status after word", b, 8'h06);
      rd(3'd3, b); w[31:24] = b;
      rd(3'd2, b); w[23:16] = b;
      rd(3'd1, b); w[15:8]  = b;
      rd(3'd0, b); w[7:0]   = b;
      check("R3 receive word", w, sl & m);
      rd(3'd7, b); check("R8 valid cleared", b, 8'h02);
    end

    // R7 back-to-back words, then R8 overrun
    wr(3'd4, 8'h01); cpol_b = 1'b0; cpha_b = 1'b0; len_b = 8;
    wr(3'd6, 8'h07);
    s_tx = 32'h11; s_tx2 = 32'h22; s_ngot = 0;
    clear_gaps();
    wr(3'd0, 8'h81);
    for (int i = 0; i < 100; i++) begin
      rd(3'd7, b);
      if (b[1]) break;
    end
    check("R7 holding empty while busy", {30'b0, b[1:0]}, 2'b11);
    wr(3'd0, 8'h7E);
    wait_idle();
    check("R7 two words", s_ngot, 2);
    check("R7 first word", s_got[0], 32'h81);
    check("R7 second word", s_got[1], 32'h7E);
    check("R7 single deselect", cs_rise, 1);
    check("R7 min spacing", gmin, 2);
    check("R7 max spacing", gmax, 2);
    rd(3'd7, b); check("R8 overrun status", b, 8'h0E);
    check("R9 irq masked", irq, 0);
    rd(3'd0, b); check("R8 newest word kept", b, 8'h22);
    rd(3'd7, b); check("R8 overrun sticky", b, 8'h0A);
    wr(3'd7, 8'h08);
    rd(3'd7, b); check("R8 overrun cleared", b, 8'h02);

    // R9 interrupt
    wr(3'd5, 8'h01);
    s_tx = 32'hC3; s_tx2 = 32'hC3;
    wr(3'd0, 8'h5A);
    wait_idle();
    check("R9 irq raised", irq, 1);
    rd(3'd0, b); check("R2 receive byte", b, 8'hC3);
    check("R9 irq dropped", irq, 0);

    // R9 manual chip select
    wr(3'd5, 8'h06);
    check("R9 forced select", cs_n, 0);
    wr(3'd5, 8'h02);
    check("R9 released select", cs_n, 1);
    wr(3'd0, 8'h33);
    repeat (3) @(negedge clk);
    rd(3'd7, b); check("R9 busy in manual", b[0], 1);
    check("R9 select held high", cs_n, 1);
    wait_idle();
    rd(3'd0, b);
    wr(3'd5, 8'h00);
    check("R6 idle deselect", cs_n, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule